// File: doc/BRIEF.md
# Carry Select Adder with Add-One Converters

This block is a purely combinational 32-bit unsigned adder. It takes two operands and a carry-in and returns the 32-bit sum together with the carry-out. Internally the operands are cut into equal groups of four bits. Each upper group adds its slice once, with an assumed carry-in of zero, using a ripple chain. It then forms the assumed carry-in-one result by adding one to that first result. A gate-level increment network does this in place of a second ripple chain. The carry that actually arrives from the group below picks which of the two results leaves the group.

The lowest group has no choice to make. It is a plain ripple adder fed directly by the external carry-in. The block has no clock, no reset and no storage, so an input change reaches the outputs within the same cycle. It is meant to sit inside a datapath wherever a wide add with a short carry path is needed and area matters more than it would for a duplicated-ripple design.

Top module: `csa_bec_adder32`

## Requirements
- R1: `sum_o` equals bits 31..0 of the unsigned sum `a_i + b_i + cin_i`.
- R2: `cout_o` equals bit 32 of the unsigned sum `a_i + b_i + cin_i`.
- R3: A carry produced in the lowest bit travels through every group: `a_i = 32'hFFFF_FFFF`, `b_i = 0`, `cin_i = 1` gives `sum_o = 0` and `cout_o = 1`.
- R4: In every upper group, the carry-in-one alternative (sum bits and carry bit) equals the carry-in-zero alternative plus one, formed by an increment network in which bit i flips exactly when all lower bits are one.
- R5: Group 0 takes `cin_i` as its carry; group k (k at least 1) selects its output using the carry leaving group k-1. A slice of ones plus one in any group k therefore yields a one in bit 4k+4 (or in `cout_o` for the top group).
- R6: The outputs depend only on the present inputs: a new input value is reflected on `sum_o` and `cout_o` without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand, unsigned |
| b_i | input | 32 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low 32 bits of the result |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
All-ones operands with both carry-in values separate a group that keeps its carry-zero result from one that switches to the incremented result. Complementary alternating patterns give a sum of all ones that a single carry-in turns into a full-length propagate, so they expose a broken selection chain. A walking slice of ones plus one in each group in turn checks every group boundary and the select path of every group, and the top group's case also checks the final carry-out. Several thousand random vectors compared against a plain reference addition catch errors in the increment network's bit terms that the structured patterns would miss.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned CSA_WIDTH = 32;
  localparam int unsigned CSA_GRP   = 4;
endpackage

// File: rtl/csa_ripple_grp.sv
module csa_ripple_grp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic prop;
    assign prop       = a_i[i] ^ b_i[i];
    assign sum_o[i]   = prop ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_i[i]) | (prop & carry[i]);
  end

  assign cout_o = carry[W];

  // R1: each ripple slice must deliver the exact slice sum
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r1_ripple_slice: assert ({cout_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("ripple slice sum mismatch");
    end
  end
endmodule

// File: rtl/csa_inc_conv.sv
module csa_inc_conv #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  // flip[i] is high when every bit below i is one; each term reuses the one below
  logic [W-1:0] flip;

  assign flip[0] = 1'b1;
  for (genvar i = 1; i < W; i++) begin : g_and
    assign flip[i] = flip[i-1] & x_i[i-1];
  end

  for (genvar i = 0; i < W; i++) begin : g_xor
    assign y_o[i] = x_i[i] ^ flip[i];
  end

  // R4: output is the input incremented by one (modulo 2^W)
  always_comb begin
    if (!$isunknown(x_i)) begin
      a_r4_plus_one: assert (y_o == W'(x_i + 1'b1))
        else $error("increment network mismatch");
    end
  end
endmodule

// File: rtl/csa_sel_grp.sv
module csa_sel_grp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned WX = W + 1;

  logic [W-1:0] sum_z;
  logic         cout_z;
  logic [WX-1:0] alt_z;
  logic [WX-1:0] alt_o;

  csa_ripple_grp #(.W(W)) u_rca (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (1'b0),
    .sum_o  (sum_z),
    .cout_o (cout_z)
  );

  assign alt_z = {cout_z, sum_z};

  csa_inc_conv #(.W(WX)) u_inc (
    .x_i (alt_z),
    .y_o (alt_o)
  );

  assign {cout_o, sum_o} = sel_i ? alt_o : alt_z;

  // R5: the chosen alternative must match the slice sum for the arriving carry
  always_comb begin
    if (!$isunknown({a_i, b_i, sel_i})) begin
      a_r5_group_select: assert ({cout_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, sel_i}))
        else $error("group select mismatch");
    end
  end
endmodule

// File: rtl/csa_bec_adder32.sv
module csa_bec_adder32
  import csa_pkg::*;
#(
  parameter int unsigned WIDTH = CSA_WIDTH,
  parameter int unsigned GRP   = CSA_GRP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NGRP = WIDTH / GRP;

  logic [NGRP:0] gcarry;

  assign gcarry[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == 0) begin : g_base
      csa_ripple_grp #(.W(GRP)) u_grp (
        .a_i    (a_i[GRP-1:0]),
        .b_i    (b_i[GRP-1:0]),
        .cin_i  (gcarry[0]),
        .sum_o  (sum_o[GRP-1:0]),
        .cout_o (gcarry[1])
      );
    end else begin : g_sel
      csa_sel_grp #(.W(GRP)) u_grp (
        .a_i    (a_i[g*GRP +: GRP]),
        .b_i    (b_i[g*GRP +: GRP]),
        .sel_i  (gcarry[g]),
        .sum_o  (sum_o[g*GRP +: GRP]),
        .cout_o (gcarry[g+1])
      );
    end
  end

  assign cout_o = gcarry[NGRP];

  // R1 / R2: full-width result against a plain addition
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r1_sum_low: assert (sum_o == WIDTH'(a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i}))
        else $error("sum mismatch");
      a_r2_carry_out: assert (cout_o ==
                              (({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}) >> WIDTH))
        else $error("carry-out mismatch");
    end
  end
endmodule

// File: tb/csa_bec_adder32_tb_top.sv
module csa_bec_adder32_tb_top;
  localparam int unsigned WIDTH = 32;
  localparam int unsigned GRP   = 4;
  localparam int unsigned NGRP  = WIDTH / GRP;
  localparam int unsigned NVEC  = 10;
  localparam int unsigned NRAND = 3000;

  // entry layout: {a, b, cin, sum, cout}
  localparam logic [97:0] TBL [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
    {32'h0000_000F, 32'h0000_0001, 1'b0, 32'h0000_0010, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
    {32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0},
    {32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, 32'h5555_5555, 1'b1}
  };

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] a;
  logic [WIDTH-1:0] b;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  csa_bec_adder32 dut_i (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [WIDTH-1:0] exp_s, input logic exp_c);
    checks++;
    if (sum !== exp_s || cout !== exp_c) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%b_%h expected=%b_%h",
               req, a, b, cin, cout, sum, exp_c, exp_s);
    end
  endtask

  task automatic apply_ref(input string req, input logic [WIDTH-1:0] va,
                           input logic [WIDTH-1:0] vb, input logic vc);
    logic [WIDTH:0] ref_v;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    ref_v = {1'b0, va} + {1'b0, vb} + {{WIDTH{1'b0}}, vc};
    check(req, ref_v[WIDTH-1:0], ref_v[WIDTH]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 table of fixed vectors
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      a   = TBL[i][97:66];
      b   = TBL[i][65:34];
      cin = TBL[i][33];
      #1;
      check("R1_R2 table", TBL[i][32:1], TBL[i][0]);
    end

    // R3 full-length propagate from the carry-in
    @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'h0; cin = 1'b1;
    #1;
    check("R3 propagate", 32'h0, 1'b1);

    // R5 walking slice of ones plus one, per group
    for (int g = 0; g < NGRP; g++) begin
      logic [WIDTH:0] exp_v;
      @(negedge clk);
      a = 32'hF << (g * GRP);
      b = 32'h1 << (g * GRP);
      cin = 1'b0;
      #1;
      exp_v = 33'h1 << ((g + 1) * GRP);
      check("R5 group carry", exp_v[WIDTH-1:0], exp_v[WIDTH]);
    end

    // R4 every group's increment path via carry-in into ones slices
    for (int g = 0; g < NGRP; g++) begin
      apply_ref("R4 increment", (32'h1 << (g * GRP)) - 32'h1, 32'h0000_0000, 1'b1);
    end

    // R6 output follows input with no clock edge in between
    @(negedge clk);
    a = 32'h0000_0001; b = 32'h0000_0001; cin = 1'b0;
    #1;
    check("R6 first", 32'h2, 1'b0);
    a = 32'hFFFF_FFFE;
    #0.5;
    check("R6 second", 32'hFFFF_FFFF, 1'b0);

    // R1 R2 random vectors against the reference sum
    for (int n = 0; n < NRAND; n++) begin
      apply_ref("R1_R2 random", $urandom, $urandom, 1'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule